// File: doc/BRIEF.md
# Frame-Checked Serial Command Port

This block is the serial command and status port of an eight-channel power driver controller. A host drives chip-select, a serial clock and a data line. While chip-select is low the port shifts command bits in, least significant bit first, and shifts a 16-bit status word out on the same bit order. Chip-select and serial clock are never used as clocks. All three pins pass through synchronizers into the system clock, and the port acts on the edges it finds there.

When chip-select rises, the port accepts the frame only if its bit count is a nonzero whole multiple of 16 and the serial clock is low. An accepted frame writes the last 16 bits received into two 8-bit command registers. The low byte holds the channel on/off commands. The high byte holds the per-channel off-state open-load check enables. For one system clock the port also raises a strobe that the fault logic uses to clear its latched faults.

In a frame longer than 16 bits, the port first sends its own status word. It then sends the data line's earlier bits, delayed by 16 bit times, so several ports can share one chain. The thermal-warning flag is status bit 0. It is on the output as soon as chip-select falls, before any clock edge, so a host can poll it without a full transfer.

Top module: `spi_cmd_port`

## Requirements
- R1: After reset, drv_en and diag_en are 0, so_oe is 0 and frame_ok is low.
- R2: Command bit i of an accepted 16-bit frame (bit 0 sent first) goes to drv_en[i] for i = 0..7 and to diag_en[i-8] for i = 8..15.
- R3: Bits are counted on serial-clock rising edges while chip-select is low. The registers are written only when the count is 16·n with n ≥ 1. A count of 0, 15 or 17 leaves both registers unchanged.
- R4: A frame whose serial clock is high when chip-select rises is rejected and leaves both registers unchanged, even with a bit count of 16.
- R5: Within 4 system clocks after chip-select falls, and before any serial-clock edge, so_oe is 1 and so_dout equals status_in[0] (thermal warning).
- R6: During a frame, so_dout presents status bit k after the k-th serial-clock falling edge, for k = 0..15. The status is taken from status_in when chip-select falls, and bits 13 and 14 always read 0.
- R7: so_oe is 0 while chip-select is high.
- R8: In a frame of more than 16 bits, the output bit at position 16+j equals the input bit received at position j. The last 16 bits received are the ones committed.
- R9: frame_ok is high for exactly one system clock per accepted frame, and it is never high for a rejected frame.
- R10: Asserting rst_n low at any time clears drv_en and diag_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (enable low or logic undervoltage) |
| csb | input | 1 | Chip-select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| si | input | 1 | Serial data in, LSB first |
| status_in | input | 16 | Parallel status word: bit 0 thermal warning, 1-8 channel faults, 9-12 PWM input levels, 15 supply fail |
| so_dout | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for the tri-state SO pad |
| drv_en | output | 8 | Channel on/off command register |
| diag_en | output | 8 | Off-state open-load check enable register |
| frame_ok | output | 1 | One-cycle strobe on an accepted frame |

## Verification
On every cycle, the assertions check four things. The command registers move only together with the strobe, and the strobe never lasts two cycles. An accepted frame always had a whole multiple of 16 bits and a low serial clock. Output enable stays off while chip-select is settled high, and the first output bit is the thermal flag taken when chip-select fell. Only the bench's scenarios can show the actual bit mapping into the registers, the order of the status bits on SO, the zeroed reserved bits and the 16-bit delay of the daisy-chain pass-through, because these need a whole serial transfer to be compared against a word.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int FRAME_W   = 16;
  localparam int IDX_W     = $clog2(FRAME_W);
  localparam logic [FRAME_W-1:0] RSVD_MASK = 16'h6000;

  // Status word as sent: reserved positions forced to zero.
  function automatic logic [FRAME_W-1:0] build_status(input logic [FRAME_W-1:0] raw);
    return raw & ~RSVD_MASK;
  endfunction

  // Next value of the modulo-frame bit index.
  function automatic logic [IDX_W-1:0] next_index(input logic [IDX_W-1:0] idx);
    return (idx == IDX_W'(FRAME_W - 1)) ? '0 : idx + 1'b1;
  endfunction

  // Frame acceptance at chip-select release.
  function automatic logic frame_accept(input logic aligned, input logic sclk_level);
    return aligned && !sclk_level;
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_async,
  output logic [W-1:0] pin_sync
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= {chain[STAGES-2:0], pin_async[b]};
    end
    assign pin_sync[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_cmd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_fall,
  input  logic               sclk_rise,
  input  logic               si_bit,
  output logic [FRAME_W-1:0] rx_word,
  output logic               last_si,
  output logic               count_aligned
);
  logic [IDX_W-1:0] bit_idx;
  logic             got_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_word <= '0;
      last_si <= 1'b0;
      bit_idx <= '0;
      got_bit <= 1'b0;
    end else if (cs_fall) begin
      bit_idx <= '0;
      got_bit <= 1'b0;
    end else if (sclk_rise) begin
      rx_word <= {si_bit, rx_word[FRAME_W-1:1]};
      last_si <= si_bit;
      bit_idx <= next_index(bit_idx);
      got_bit <= 1'b1;
    end
  end

  assign count_aligned = got_bit && (bit_idx == '0);
endmodule

// File: rtl/spi_status_tx.sv
module spi_status_tx
  import spi_cmd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_fall,
  input  logic               cs_rise,
  input  logic               sclk_fall,
  input  logic [FRAME_W-1:0] status_word,
  input  logic               fill_bit,
  output logic               so_dout,
  output logic               so_oe
);
  logic [FRAME_W-1:0] tx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0;
      so_oe <= 1'b0;
    end else if (cs_fall) begin
      tx_sr <= build_status(status_word);
      so_oe <= 1'b1;
    end else if (cs_rise) begin
      so_oe <= 1'b0;
    end else if (sclk_fall && so_oe) begin
      tx_sr <= {fill_bit, tx_sr[FRAME_W-1:1]};
    end
  end

  assign so_dout = so_oe & tx_sr[0];
endmodule

// File: rtl/spi_cmd_port.sv
module spi_cmd_port
  import spi_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  localparam int CH = FRAME_W / 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               csb,
  input  logic               sclk,
  input  logic               si,
  input  logic [FRAME_W-1:0] status_in,
  output logic               so_dout,
  output logic               so_oe,
  output logic [CH-1:0]      drv_en,
  output logic [CH-1:0]      diag_en,
  output logic               frame_ok
);
  logic [2:0] pins_sync;
  logic       csb_sync, sclk_sync, si_sync;
  logic       csb_q, sclk_q;
  logic       cs_fall, cs_rise, sclk_rise, sclk_fall;
  logic [FRAME_W-1:0] rx_word;
  logic       last_si, count_aligned, accept;

  spi_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .pin_async({si, sclk, csb}), .pin_sync(pins_sync)
  );
  assign csb_sync  = pins_sync[0];
  assign sclk_sync = pins_sync[1];
  assign si_sync   = pins_sync[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csb_q  <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      csb_q  <= csb_sync;
      sclk_q <= sclk_sync;
    end
  end

  assign cs_fall   = csb_q & ~csb_sync;
  assign cs_rise   = ~csb_q & csb_sync;
  assign sclk_rise = ~csb_sync & ~csb_q & ~sclk_q & sclk_sync;
  assign sclk_fall = ~csb_sync & ~csb_q & sclk_q & ~sclk_sync;

  spi_frame_rx u_rx (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .sclk_rise(sclk_rise),
    .si_bit(si_sync), .rx_word(rx_word), .last_si(last_si),
    .count_aligned(count_aligned)
  );

  spi_status_tx u_tx (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_fall(sclk_fall), .status_word(status_in), .fill_bit(last_si),
    .so_dout(so_dout), .so_oe(so_oe)
  );

  assign accept = cs_rise && frame_accept(count_aligned, sclk_sync);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_en   <= '0;
      diag_en  <= '0;
      frame_ok <= 1'b0;
    end else begin
      frame_ok <= accept;
      if (accept) begin
        drv_en  <= rx_word[CH-1:0];
        diag_en <= rx_word[FRAME_W-1:CH];
      end
    end
  end
endmodule

// File: rtl/spi_cmd_port_chk.sv
module spi_cmd_port_chk #(
  parameter int CH = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_ok,
  input logic [CH-1:0] drv_en,
  input logic [CH-1:0] diag_en,
  input logic          so_oe,
  input logic          so_dout,
  input logic          status_tw,
  input logic          csb_sync,
  input logic          sclk_sync,
  input logic          count_aligned
);
  // R9
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |=> !frame_ok);

  // R3
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_ok |-> ($stable(drv_en) && $stable(diag_en)));

  // R3
  count_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |-> $past(count_aligned));

  // R4
  sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |-> $past(!sclk_sync));

  // R7
  so_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csb_sync && $past(csb_sync)) |-> !so_oe);

  // R5
  tw_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(so_oe) |-> (so_dout == $past(status_tw)));
endmodule

bind spi_cmd_port spi_cmd_port_chk #(.CH(CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok), .drv_en(drv_en),
  .diag_en(diag_en), .so_oe(so_oe), .so_dout(so_dout),
  .status_tw(status_in[0]), .csb_sync(csb_sync), .sclk_sync(sclk_sync),
  .count_aligned(count_aligned)
);

// File: tb/sim_spi_cmd_port.sv
module sim_spi_cmd_port;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csb = 1'b1, sclk = 1'b0, si = 1'b0;
  logic [15:0] status_in = '0;
  logic so_dout, so_oe, frame_ok;
  logic [7:0] drv_en, diag_en;

  int checks = 0, errors = 0, pulses = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spi_cmd_port u0 (
    .clk(clk), .rst_n(rst_n), .csb(csb), .sclk(sclk), .si(si),
    .status_in(status_in), .so_dout(so_dout), .so_oe(so_oe),
    .drv_en(drv_en), .diag_en(diag_en), .frame_ok(frame_ok)
  );

  always @(negedge clk) if (rst_n && frame_ok) pulses++;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Runs one transfer; returns the SO bits seen before each rising edge.
  task automatic xfer(input logic [63:0] data, input int nbits, input bit end_high,
                      input logic [15:0] st, output logic [63:0] so_bits, output int np);
    int p0;
    so_bits = '0;
    p0 = pulses;
    status_in = st;
    @(negedge clk);
    csb = 1'b0;
    waitc(5);
    chk(so_oe == 1'b1 && so_dout == st[0], "R5 thermal bit at cs fall", {so_oe, so_dout}, {1'b1, st[0]});
    waitc(H);
    for (int i = 0; i < nbits; i++) begin
      si = data[i];
      waitc(H);
      so_bits[i] = so_dout;
      sclk = 1'b1;
      waitc(H);
      if (!(end_high && i == nbits - 1)) sclk = 1'b0;
    end
    waitc(H);
    csb = 1'b1;
    waitc(H);
    sclk = 1'b0;
    waitc(2 * H);
    chk(so_oe == 1'b0, "R7 so_oe low with csb high", so_oe, 0);
    np = pulses - p0;
  endtask

  task automatic t_reset();
    chk(drv_en == 0 && diag_en == 0, "R1 regs after reset", {diag_en, drv_en}, 0);
    chk(so_oe == 0 && frame_ok == 0, "R1 so_oe/frame_ok after reset", {so_oe, frame_ok}, 0);
  endtask

  task automatic t_basic(input logic [15:0] cmd, input logic [15:0] st);
    logic [63:0] sb; int np;
    logic [15:0] exp_st;
    exp_st = st & 16'h9FFF;
    xfer({48'd0, cmd}, 16, 0, st, sb, np);
    chk(drv_en == cmd[7:0], "R2 drv_en from bits 0-7", drv_en, cmd[7:0]);
    chk(diag_en == cmd[15:8], "R2 diag_en from bits 8-15", diag_en, cmd[15:8]);
    chk(sb[15:0] == exp_st, "R6 status order and reserved bits", sb[15:0], exp_st);
    chk(np == 1, "R9 one strobe per accepted frame", np, 1);
  endtask

  task automatic t_bad_len(input int n);
    logic [63:0] sb; int np;
    logic [7:0] d0, g0;
    d0 = drv_en; g0 = diag_en;
    xfer(64'h0123_4567_89AB_CDEF, n, 0, 16'h0000, sb, np);
    chk(drv_en == d0 && diag_en == g0, $sformatf("R3 count %0d rejected", n), {diag_en, drv_en}, {g0, d0});
    chk(np == 0, "R9 no strobe on rejected frame", np, 0);
  endtask

  task automatic t_sclk_high();
    logic [63:0] sb; int np;
    logic [7:0] d0, g0;
    d0 = drv_en; g0 = diag_en;
    xfer(64'h0000_0000_0000_FFFF, 16, 1, 16'h0001, sb, np);
    chk(drv_en == d0 && diag_en == g0, "R4 sclk high at cs rise rejected", {diag_en, drv_en}, {g0, d0});
    chk(np == 0, "R4 R9 no strobe", np, 0);
  endtask

  task automatic t_chain();
    logic [63:0] sb; int np;
    logic [15:0] first, last;
    first = 16'hC3A1; last = 16'h5E96;
    xfer({32'd0, last, first}, 32, 0, 16'hFFFF, sb, np);
    chk(sb[31:16] == first, "R8 pass-through delayed 16 bits", sb[31:16], first);
    chk(sb[15:0] == 16'h9FFF, "R6 own status first in chain", sb[15:0], 16'h9FFF);
    chk({diag_en, drv_en} == last, "R8 last 16 bits committed", {diag_en, drv_en}, last);
    chk(np == 1, "R9 strobe on 32-bit frame", np, 1);
  endtask

  task automatic t_midreset();
    rst_n = 1'b0;
    waitc(3);
    chk(drv_en == 0 && diag_en == 0, "R10 reset clears regs", {diag_en, drv_en}, 0);
    rst_n = 1'b1;
    waitc(4);
  endtask

  initial begin
    waitc(5);
    rst_n = 1'b1;
    waitc(4);
    t_reset();
    t_basic(16'hA53C, 16'h7FFF);
    t_basic(16'h5AC3, 16'hE1F0);
    t_bad_len(15);
    t_bad_len(17);
    t_bad_len(0);
    t_sclk_high();
    t_chain();
    t_midreset();
    t_basic(16'h0181, 16'h6001);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule